// File: doc/BRIEF.md
# Brushless Motor Bridge Gating Stage

This block sits between a commutation decoder and the six switches of a three-phase bridge. It takes the high-side and low-side commutation enables and decides whether each bridge output may be on. It applies a brake, a drive enable, overcurrent protection and pulse-width speed control.

Speed control uses a free-running sawtooth counter, compared against a threshold word. Only the low-side outputs are gated by it, so the high-side switches change state at the commutation rate alone.

An overcurrent bit blanks every output at once and sets a fault latch. The latch re-arms only on a rising edge of the enable input, or at the start of a sawtooth period, and only when the fault bit is low at that moment. This keeps fault cycling to the chopping rate.

A chop mode lets a pulsed enable input do the speed control in place of the sawtooth. In that mode the counter is held at zero and takes no part. All inputs are synchronous to one clock.

Top module: `bldc_gate_top`

## Requirements
- R1: While `brakeIn` is 1, `outHi` is all zeros and `outLo` is all ones in the same cycle. This holds whatever the values of every other input and of the fault latch.
- R2: Braking overrides overcurrent. With `ocFault` high or the latch set, `brakeIn` high still gives `outLo` all ones. A latch that is still set blanks the outputs again once the brake drops.
- R3: With `brakeIn` 0 and `enableIn` 0, all six outputs are 0 in the same cycle.
- R4: With `brakeIn` 0, `ocFault` high turns off all six outputs in the same cycle. On the next clock edge it sets a latch, and the latch keeps all outputs off after `ocFault` falls.
- R5: The latch clears on a clock edge where `ocFault` is 0 and a clear event is seen. A clear event is either an enable rising edge (`enableIn` 1 now and 0 on the previous edge) or a period start (the sawtooth count is 0 while chop mode is off). An event that coincides with `ocFault` high leaves the latch set.
- R6: In sawtooth mode, and when not blanked, `outHi` equals `cmdHi` in every cycle. `outLo` equals `cmdLo` only in cycles where `speedThr` is less than the sawtooth count, and is 0 otherwise.
- R7: A `speedThr` of 0 gives `outLo` = `cmdLo` in every cycle, including count 0. A `speedThr` of all ones (255 by default) keeps `outLo` at 0 in every cycle.
- R8: With `chopMode` 1, the sawtooth is held at 0 and `outLo` is not PWM-gated. Period start is suppressed, so only an enable rising edge can clear the latch.
- R9: In sawtooth mode the count rises by one every clock and wraps from its maximum to 0.
- R10: After reset the latch is clear, the count is 0 and the edge detector's previous-enable flop is 0. A high `enableIn` on the first edge after reset therefore counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdHi | input | 3 | High-side commutation enables, one per phase |
| cmdLo | input | 3 | Low-side commutation enables, one per phase |
| brakeIn | input | 1 | Brake request, highest priority |
| enableIn | input | 1 | Drive enable; pulsed in chop mode |
| ocFault | input | 1 | Overcurrent comparator bit, 1 = fault |
| speedThr | input | 8 | Speed threshold compared with the sawtooth count |
| chopMode | input | 1 | 1 = speed set by a pulsed enable, sawtooth held |
| outHi | output | 3 | High-side bridge drives |
| outLo | output | 3 | Low-side bridge drives |

## Verification
A fault latch wrongly left set shows as blank outputs with `ocFault` low. A wrongly cleared latch shows as drive returning before the next enable edge or count-zero cycle. Either shows within one period of the sawtooth, at most 256 cycles.

A count that is off by one, or that runs in chop mode, moves the low-side on/off boundary. This is visible on `outLo` in the first period after the mismatch. A wrong priority among brake, fault and enable shows in the same cycle as the input that exposes it.

The reference model in the bench tracks count, edge flop and latch on its own. It compares both output buses every cycle, so any divergence is reported on the clock where it first appears.

// File: rtl/bldc_gate_pkg.sv
package bldc_gate_pkg;
  typedef struct packed {
    logic blankAll;
    logic sawHold;
  } gate_strobe_t;
endpackage

// File: rtl/bldc_gate_ctrl.sv
module bldc_gate_ctrl
  import bldc_gate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enableIn,
  input  logic         ocFault,
  input  logic         chopMode,
  input  logic         periodStart,
  output gate_strobe_t strobes,
  output logic         faultLatched
);
  logic enPrev;
  logic enRise;
  logic clearEvt;
  logic latchQ;

  assign enRise   = enableIn & ~enPrev;
  assign clearEvt = enRise | periodStart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enPrev <= 1'b0;
      latchQ <= 1'b0;
    end else begin
      enPrev <= enableIn;
      if (ocFault)       latchQ <= 1'b1;
      else if (clearEvt) latchQ <= 1'b0;
    end
  end

  always_comb begin
    strobes.blankAll = ocFault | latchQ | ~enableIn;
    strobes.sawHold  = chopMode;
  end

  assign faultLatched = latchQ;
endmodule

// File: rtl/bldc_gate_dp.sv
module bldc_gate_dp
  import bldc_gate_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int NUM_PH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  gate_strobe_t      strobes,
  input  logic              brakeIn,
  input  logic [NUM_PH-1:0] cmdHi,
  input  logic [NUM_PH-1:0] cmdLo,
  input  logic [CNT_W-1:0]  speedThr,
  output logic [NUM_PH-1:0] outHi,
  output logic [NUM_PH-1:0] outLo,
  output logic              periodStart,
  output logic [CNT_W-1:0]  sawVal
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] sawCnt;
  logic             pwmOn;

  always_ff @(posedge clk) begin
    if (!rstN)                sawCnt <= '0;
    else if (strobes.sawHold) sawCnt <= '0;
    else                      sawCnt <= sawCnt + CNT_ONE;
  end

  assign periodStart = ~strobes.sawHold & (sawCnt == '0);
  assign pwmOn = strobes.sawHold | (speedThr == '0) | (speedThr < sawCnt);
  assign sawVal = sawCnt;

  for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
    always_comb begin
      if (brakeIn) begin
        outHi[p] = 1'b0;
        outLo[p] = 1'b1;
      end else if (strobes.blankAll) begin
        outHi[p] = 1'b0;
        outLo[p] = 1'b0;
      end else begin
        outHi[p] = cmdHi[p];
        outLo[p] = cmdLo[p] & pwmOn;
      end
    end
  end
endmodule

// File: rtl/bldc_gate_top.sv
module bldc_gate_top
  import bldc_gate_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int NUM_PH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_PH-1:0] cmdHi,
  input  logic [NUM_PH-1:0] cmdLo,
  input  logic              brakeIn,
  input  logic              enableIn,
  input  logic              ocFault,
  input  logic [CNT_W-1:0]  speedThr,
  input  logic              chopMode,
  output logic [NUM_PH-1:0] outHi,
  output logic [NUM_PH-1:0] outLo
);
  gate_strobe_t     strobes;
  logic             periodStart;
  logic             faultLatched;
  logic [CNT_W-1:0] sawVal;

  bldc_gate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enableIn(enableIn), .ocFault(ocFault),
    .chopMode(chopMode), .periodStart(periodStart),
    .strobes(strobes), .faultLatched(faultLatched)
  );

  bldc_gate_dp #(.CNT_W(CNT_W), .NUM_PH(NUM_PH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .brakeIn(brakeIn),
    .cmdHi(cmdHi), .cmdLo(cmdLo), .speedThr(speedThr),
    .outHi(outHi), .outLo(outLo), .periodStart(periodStart), .sawVal(sawVal)
  );
endmodule

// File: rtl/bldc_gate_checker.sv
module bldc_gate_checker #(
  parameter int CNT_W  = 8,
  parameter int NUM_PH = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_PH-1:0] cmdHi,
  input logic [NUM_PH-1:0] cmdLo,
  input logic              brakeIn,
  input logic              enableIn,
  input logic              ocFault,
  input logic              chopMode,
  input logic [NUM_PH-1:0] outHi,
  input logic [NUM_PH-1:0] outLo,
  input logic [CNT_W-1:0]  sawVal
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  AST_BRAKE_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    brakeIn |-> (outHi == '0 && outLo == '1)); // R1
  AST_BRAKE_OVER_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (brakeIn && ocFault) |-> (outLo == '1)); // R2
  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!brakeIn && !enableIn) |-> (outHi == '0 && outLo == '0)); // R3
  AST_FAULT_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    (!brakeIn && ocFault) |-> (outHi == '0 && outLo == '0)); // R4
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ocFault && !brakeIn) |=> (brakeIn || $rose(enableIn) || sawVal == '0 ||
                               (outHi == '0 && outLo == '0))); // R5
  AST_CMD_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    !brakeIn |-> ((outHi & ~cmdHi) == '0 && (outLo & ~cmdLo) == '0)); // R6
  AST_CHOP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    chopMode |=> (sawVal == '0)); // R8
  AST_SAW_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(chopMode)) |-> (sawVal == $past(sawVal) + CNT_ONE)); // R9
endmodule

bind bldc_gate_top bldc_gate_checker #(.CNT_W(CNT_W), .NUM_PH(NUM_PH)) u_chk (
  .clk(clk), .rstN(rstN), .cmdHi(cmdHi), .cmdLo(cmdLo), .brakeIn(brakeIn),
  .enableIn(enableIn), .ocFault(ocFault), .chopMode(chopMode),
  .outHi(outHi), .outLo(outLo), .sawVal(sawVal)
);

// File: tb/bldc_gate_top_tb_top.sv
module bldc_gate_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] cmdHi = 3'b000;
  logic [2:0] cmdLo = 3'b000;
  logic       brakeIn = 1'b0;
  logic       enableIn = 1'b0;
  logic       ocFault = 1'b0;
  logic [7:0] speedThr = 8'd0;
  logic       chopMode = 1'b0;
  logic [2:0] outHi;
  logic [2:0] outLo;

  int    checks = 0;
  int    errors = 0;
  string tag = "R10";
  bit    finished = 1'b0;

  // reference state
  int mCnt = 0;
  bit mEnPrev = 0;
  bit mLatch = 0;

  always #2 clk = ~clk;

  bldc_gate_top dut_i (
    .clk(clk), .rstN(rstN), .cmdHi(cmdHi), .cmdLo(cmdLo), .brakeIn(brakeIn),
    .enableIn(enableIn), .ocFault(ocFault), .speedThr(speedThr),
    .chopMode(chopMode), .outHi(outHi), .outLo(outLo)
  );

  task automatic modelEdge();
    bit ps, er;
    if (!rstN) begin
      mCnt = 0; mEnPrev = 0; mLatch = 0;
    end else begin
      ps = !chopMode && mCnt == 0;
      er = enableIn && !mEnPrev;
      if (ocFault) mLatch = 1;
      else if (ps || er) mLatch = 0;
      mEnPrev = enableIn;
      mCnt = chopMode ? 0 : (mCnt + 1) % 256;
    end
  endtask

  task automatic compareNow();
    logic [2:0] eHi, eLo;
    bit pwm;
    pwm = chopMode || speedThr == 0 || int'(speedThr) < mCnt;
    if (brakeIn) begin
      eHi = 3'b000; eLo = 3'b111;
    end else if (!enableIn || ocFault || mLatch) begin
      eHi = 3'b000; eLo = 3'b000;
    end else begin
      eHi = cmdHi; eLo = pwm ? cmdLo : 3'b000;
    end
    checks++;
    if (outHi !== eHi || outLo !== eLo) begin
      errors++;
      $display("FAIL %s: outHi=%b outLo=%b expected outHi=%b outLo=%b (cnt=%0d)",
               tag, outHi, outLo, eHi, eLo, mCnt);
    end
  endtask

  // one clock: posedge happens, then at negedge model and compare
  task automatic step();
    @(negedge clk);
    modelEdge();
    #0.5 compareNow();
  endtask

  task automatic randCmd();
    cmdHi = 3'($urandom);
    cmdLo = 3'($urandom);
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    tag = "R10";
    repeat (3) step();
    cmdHi = 3'b001; cmdLo = 3'b100; enableIn = 1'b1; speedThr = 8'd0;
    rstN = 1'b1;
    repeat (20) step();

    // R6 and R9: sawtooth PWM with mid threshold
    tag = "R6";
    speedThr = 8'd100;
    for (int i = 0; i < 700; i++) begin
      if (i % 37 == 0) randCmd();
      step();
    end
    tag = "R9";
    speedThr = 8'd254;
    for (int i = 0; i < 600; i++) begin
      if (i % 50 == 0) randCmd();
      step();
    end

    // R7: threshold extremes
    tag = "R7";
    cmdLo = 3'b111; cmdHi = 3'b010;
    speedThr = 8'd0;
    repeat (300) step();
    speedThr = 8'd255;
    repeat (300) step();

    // R1: brake with random everything
    tag = "R1";
    brakeIn = 1'b1;
    for (int i = 0; i < 200; i++) begin
      randCmd();
      enableIn = 1'($urandom);
      ocFault = 1'($urandom);
      speedThr = 8'($urandom);
      step();
    end
    brakeIn = 1'b0; ocFault = 1'b0; enableIn = 1'b1; speedThr = 8'd20;
    repeat (300) step();

    // R2: fault latched then brake applied, released
    tag = "R2";
    cmdHi = 3'b100; cmdLo = 3'b001;
    repeat (5) step();
    ocFault = 1'b1; step(); ocFault = 1'b0;
    brakeIn = 1'b1; repeat (10) step();
    brakeIn = 1'b0; repeat (300) step();

    // R3: enable low
    tag = "R3";
    enableIn = 1'b0;
    for (int i = 0; i < 100; i++) begin
      randCmd();
      step();
    end
    enableIn = 1'b1;
    repeat (10) step();

    // R4: fault pulses at varied points
    tag = "R4";
    speedThr = 8'd50;
    cmdHi = 3'b011; cmdLo = 3'b110;
    for (int i = 0; i < 1200; i++) begin
      ocFault = ((i % 97) < 3);
      step();
    end
    ocFault = 1'b0;

    // R5: clear by enable rising edge, and edge coinciding with fault
    tag = "R5";
    repeat (260) step();
    for (int k = 0; k < 6; k++) begin
      ocFault = 1'b1; step();
      ocFault = 1'b0; repeat (4) step();
      enableIn = 1'b0; step();
      ocFault = (k % 2 == 0);
      enableIn = 1'b1; step();
      ocFault = 1'b0; repeat (20) step();
    end
    repeat (300) step();

    // R8: chop mode with pulsed enable
    tag = "R8";
    chopMode = 1'b1; speedThr = 8'd200;
    cmdHi = 3'b001; cmdLo = 3'b010;
    for (int i = 0; i < 1500; i++) begin
      enableIn = ((i % 16) < 10);
      ocFault = ((i % 211) == 5) || ((i % 211) == 6);
      if (i % 300 == 0) randCmd();
      step();
    end
    ocFault = 1'b0; enableIn = 1'b1;
    repeat (10) step();
    chopMode = 1'b0;
    repeat (300) step();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule